// File: doc/BRIEF.md
# PCI Base Address Register Bank with Window Decoder

This block holds the six base address registers of a type-0 PCI configuration header and turns their programmed values into address windows. Configuration software reaches it with a dword offset, byte enables and write data. A read returns the register at that offset on the following cycle. Parameters fix the size of each register's window and whether the window claims memory or I/O space. The read-only low bits report that choice.

Software sizes a register by writing all ones to it and reading the value back. A later write of a real base address opens a decode window at that base, or moves the window if one is already open. For every register the block outputs an enable, a base and a mask. It also has a combinational decoder that tells which register, if any, claims a given address and space type.

Top module: `cfg_bar_bank`

## Requirements
- R1: After reset, every I/O register reads 0x00000001, every memory register reads 0x00000000, and `win_en` is all zero.
- R2: Register n (0..5) sits at dword offset 4+n, which is byte offset 0x10+4n. A read of any other offset returns zero. A write to any other offset changes no register and no window.
- R3: A write with `cfg_be`=4'b1111 and data 0xFFFFFFFF is a sizing probe. The register then reads back ~(size-1) with the hardwired low bits ORed in.
- R4: A sizing probe leaves `win_en` and `win_base` unchanged.
- R5: On any other write, I/O registers keep bits [1:0] at 2'b01 and memory registers keep bits [3:0] at 4'b0000. All other bits take the written value.
- R6: On a partial write, bytes whose enable bit is low keep their previous contents. The read-only low bits are still enforced.
- R7: A non-probe write opens the window when the new register value ANDed with ~(size-1) is nonzero. `win_en` goes high and `win_base` takes that value. `win_mask` always equals size-1.
- R8: A later write with a nonzero base moves the window to the new base. A write whose base is zero leaves the window enabled at its old base. Only writes change a window.
- R9: `dec_hit` is high when some enabled window has a matching space type (`dec_is_io`=1 for I/O) and `dec_addr` & ~mask equals its base. On a miss `dec_bar` is 0.
- R10: When several windows match, `dec_bar` reports the lowest-numbered one.
- R11: `cfg_rdata` updates in the cycle after `cfg_rd` is sampled high and holds its value when no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_dw_addr | input | 6 | Dword offset into the configuration header |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| win_en | output | 6 | Window enable per register |
| win_base | output | 192 | Window base per register, 32 bits each, register n at [32n+31:32n] |
| win_mask | output | 192 | Window mask (size-1) per register, same packing |
| dec_addr | input | 32 | Address to decode |
| dec_is_io | input | 1 | Space type of the decoded address, 1 for I/O |
| dec_hit | output | 1 | Some window claims the address |
| dec_bar | output | 3 | Index of the claiming register |

## Verification
Register contents and window outputs change at the clock edge that samples the write. The bench drives each write on a falling edge and checks the windows one time unit after the next rising edge. Read data appears one edge after the read strobe, and the bench samples it at the same point after that edge. It also confirms that the data stays unchanged across a later write that has no read. The decoder is combinational over the window registers, so the bench sets the address on a falling edge and checks the hit and index a time unit later, with no clock edge in between.

// File: rtl/cfg_bar_pkg.sv
package cfg_bar_pkg;

    localparam int unsigned DW_BITS      = 32;
    localparam int unsigned FIRST_BAR_DW = 4;   // byte offset 0x10 / 4
    localparam int unsigned LOG2_FIELD_W = 5;

    typedef logic [DW_BITS-1:0] dword_t;

    typedef enum logic {
        SPACE_MEM = 1'b0,
        SPACE_IO  = 1'b1
    } space_e;

    typedef struct packed {
        logic       wr;
        logic [3:0] be;
        dword_t     data;
    } slot_wr_t;

    typedef struct packed {
        logic   en;
        dword_t base;
        dword_t mask;
    } window_t;

    function automatic dword_t fixed_bits_mask(space_e s);
        return (s == SPACE_IO) ? 32'h0000_0003 : 32'h0000_000F;
    endfunction

    function automatic dword_t fixed_bits_value(space_e s);
        return (s == SPACE_IO) ? 32'h0000_0001 : 32'h0000_0000;
    endfunction

    function automatic dword_t byte_merge(dword_t old_v, dword_t new_v, logic [3:0] be);
        dword_t r;
        for (int b = 0; b < 4; b++) begin
            r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic is_probe(logic [3:0] be, dword_t data);
        return (be == 4'hF) && (data == 32'hFFFF_FFFF);
    endfunction

endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
    import cfg_bar_pkg::*;
#(
    parameter bit          IS_IO     = 1'b0,
    parameter int unsigned LOG2_SIZE = 12
) (
    input  logic     clk,
    input  logic     rst,
    input  slot_wr_t wr_i,
    output dword_t   bar_value,
    output window_t  window
);
    localparam space_e SPACE   = IS_IO ? SPACE_IO : SPACE_MEM;
    localparam dword_t SIZE_M1 = dword_t'((64'd1 << LOG2_SIZE) - 64'd1);
    localparam dword_t FIX_M   = fixed_bits_mask(SPACE);
    localparam dword_t FIX_V   = fixed_bits_value(SPACE);

    dword_t bar_q;
    dword_t base_q;
    logic   en_q;

    dword_t merged;
    dword_t bar_d;
    dword_t base_d;
    logic   probe;

    always_comb begin
        merged = byte_merge(bar_q, wr_i.data, wr_i.be);
        probe  = is_probe(wr_i.be, wr_i.data);
        if (probe) begin
            bar_d = (~SIZE_M1 & ~FIX_M) | FIX_V;
        end else begin
            bar_d = (merged & ~FIX_M) | FIX_V;
        end
        base_d = bar_d & ~SIZE_M1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bar_q  <= FIX_V;
            base_q <= '0;
            en_q   <= 1'b0;
        end else if (wr_i.wr) begin
            bar_q <= bar_d;
            if (!probe && (base_d != '0)) begin
                base_q <= base_d;
                en_q   <= 1'b1;
            end
        end
    end

    assign bar_value   = bar_q;
    assign window.en   = en_q;
    assign window.base = base_q;
    assign window.mask = SIZE_M1;

endmodule

// File: rtl/cfg_bar_decode.sv
module cfg_bar_decode
    import cfg_bar_pkg::*;
#(
    parameter int unsigned           NUM_BARS = 6,
    parameter logic [NUM_BARS-1:0]   BAR_IO   = '0,
    localparam int unsigned          IDX_W    = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
    input  window_t [NUM_BARS-1:0] windows,
    input  dword_t                 addr,
    input  logic                   is_io,
    output logic                   hit,
    output logic [IDX_W-1:0]       idx
);
    logic [NUM_BARS-1:0] match;

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_match
        assign match[g] = windows[g].en
                        && (BAR_IO[g] == is_io)
                        && ((addr & ~windows[g].mask) == windows[g].base);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int k = NUM_BARS - 1; k >= 0; k--) begin
            if (match[k]) idx = IDX_W'(k);
        end
    end

endmodule

// File: rtl/cfg_bar_bank.sv
module cfg_bar_bank
    import cfg_bar_pkg::*;
#(
    parameter int unsigned                   NUM_BARS  = 6,
    parameter int unsigned                   ADDR_DW_W = 6,
    parameter logic [NUM_BARS-1:0]           BAR_IO    = 6'b001010,
    parameter logic [NUM_BARS*5-1:0]         BAR_LOG2  = {5'd4, 5'd16, 5'd4, 5'd20, 5'd8, 5'd12},
    localparam int unsigned                  IDX_W     = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr,
    input  logic                     cfg_rd,
    input  logic [ADDR_DW_W-1:0]     cfg_dw_addr,
    input  logic [3:0]               cfg_be,
    input  logic [31:0]              cfg_wdata,
    output logic [31:0]              cfg_rdata,
    output logic [NUM_BARS-1:0]      win_en,
    output logic [NUM_BARS*32-1:0]   win_base,
    output logic [NUM_BARS*32-1:0]   win_mask,
    input  logic [31:0]              dec_addr,
    input  logic                     dec_is_io,
    output logic                     dec_hit,
    output logic [IDX_W-1:0]         dec_bar
);
    window_t [NUM_BARS-1:0] windows;
    dword_t  [NUM_BARS-1:0] bar_vals;
    dword_t                 rd_mux;

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_slot
        slot_wr_t slot_wr;
        assign slot_wr.wr   = cfg_wr && (cfg_dw_addr == ADDR_DW_W'(FIRST_BAR_DW + g));
        assign slot_wr.be   = cfg_be;
        assign slot_wr.data = cfg_wdata;

        cfg_bar_slot #(
            .IS_IO     (BAR_IO[g]),
            .LOG2_SIZE (int'(BAR_LOG2[g*LOG2_FIELD_W +: LOG2_FIELD_W]))
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_i      (slot_wr),
            .bar_value (bar_vals[g]),
            .window    (windows[g])
        );

        assign win_en[g]           = windows[g].en;
        assign win_base[g*32 +: 32] = windows[g].base;
        assign win_mask[g*32 +: 32] = windows[g].mask;
    end

    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NUM_BARS; k++) begin
            if (cfg_dw_addr == ADDR_DW_W'(FIRST_BAR_DW + k)) rd_mux = bar_vals[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rdata <= '0;
        end else if (cfg_rd) begin
            cfg_rdata <= rd_mux;
        end
    end

    cfg_bar_decode #(
        .NUM_BARS (NUM_BARS),
        .BAR_IO   (BAR_IO)
    ) u_decode (
        .windows (windows),
        .addr    (dec_addr),
        .is_io   (dec_is_io),
        .hit     (dec_hit),
        .idx     (dec_bar)
    );

endmodule

// File: rtl/cfg_bar_bank_chk.sv
module cfg_bar_bank_chk #(
    parameter int unsigned NUM_BARS  = 6,
    parameter int unsigned ADDR_DW_W = 6,
    parameter int unsigned IDX_W     = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cfg_wr,
    input logic                   cfg_rd,
    input logic [ADDR_DW_W-1:0]   cfg_dw_addr,
    input logic [3:0]             cfg_be,
    input logic [31:0]            cfg_wdata,
    input logic [31:0]            cfg_rdata,
    input logic [NUM_BARS-1:0]    win_en,
    input logic [NUM_BARS*32-1:0] win_base,
    input logic [NUM_BARS*32-1:0] win_mask,
    input logic                   dec_hit,
    input logic [IDX_W-1:0]       dec_bar
);
    logic sizing;
    logic off_bank;
    logic aligned;

    always_comb begin
        sizing   = cfg_wr && (cfg_be == 4'hF) && (cfg_wdata == 32'hFFFF_FFFF);
        off_bank = (int'(cfg_dw_addr) < 4) || (int'(cfg_dw_addr) >= 4 + int'(NUM_BARS));
        aligned  = 1'b1;
        for (int k = 0; k < NUM_BARS; k++) begin
            if ((win_base[k*32 +: 32] & win_mask[k*32 +: 32]) != '0) aligned = 1'b0;
        end
    end

    AST_PROBE_KEEPS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        sizing |=> ($stable(win_en) && $stable(win_base))); // R4

    AST_NO_WRITE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> ($stable(win_en) && $stable(win_base))); // R8

    AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> ((~win_en & $past(win_en)) == '0)); // R7

    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        aligned); // R7

    AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (rst)
        dec_hit |-> win_en[dec_bar]); // R9

    AST_MISS_INDEX_ZERO: assert property (@(posedge clk) disable iff (rst)
        !dec_hit |-> (dec_bar == '0)); // R9

    AST_OFF_BANK_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd && off_bank) |=> (cfg_rdata == '0)); // R2

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd |=> $stable(cfg_rdata)); // R11

endmodule

bind cfg_bar_bank cfg_bar_bank_chk #(
    .NUM_BARS  (NUM_BARS),
    .ADDR_DW_W (ADDR_DW_W),
    .IDX_W     (IDX_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr      (cfg_wr),
    .cfg_rd      (cfg_rd),
    .cfg_dw_addr (cfg_dw_addr),
    .cfg_be      (cfg_be),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .win_en      (win_en),
    .win_base    (win_base),
    .win_mask    (win_mask),
    .dec_hit     (dec_hit),
    .dec_bar     (dec_bar)
);

// File: tb/cfg_bar_bank_bench.sv
module cfg_bar_bank_bench;

    localparam int NB = 6;
    localparam logic [NB-1:0]   IO_MAP = 6'b001010;
    localparam logic [NB*5-1:0] L2_MAP = {5'd4, 5'd16, 5'd4, 5'd20, 5'd8, 5'd12};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [5:0]  cfg_dw_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [NB-1:0]    win_en;
    logic [NB*32-1:0] win_base;
    logic [NB*32-1:0] win_mask;
    logic [31:0] dec_addr = '0;
    logic        dec_is_io = 1'b0;
    logic        dec_hit;
    logic [2:0]  dec_bar;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    cfg_bar_bank #(
        .NUM_BARS  (NB),
        .ADDR_DW_W (6),
        .BAR_IO    (IO_MAP),
        .BAR_LOG2  (L2_MAP)
    ) u_cfg_bar_bank (
        .clk (clk), .rst (rst), .cfg_wr (cfg_wr), .cfg_rd (cfg_rd),
        .cfg_dw_addr (cfg_dw_addr), .cfg_be (cfg_be), .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata), .win_en (win_en), .win_base (win_base),
        .win_mask (win_mask), .dec_addr (dec_addr), .dec_is_io (dec_is_io),
        .dec_hit (dec_hit), .dec_bar (dec_bar)
    );

    function automatic logic [31:0] size_m1(int i);
        return (32'd1 << L2_MAP[i*5 +: 5]) - 32'd1;
    endfunction

    function automatic logic [31:0] low_fixed(int i);
        return IO_MAP[i] ? 32'h1 : 32'h0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw_addr = a; cfg_be = be; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_dw_addr = a;
        @(posedge clk); #1;
        cfg_rd = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic expect_bar(input int i, input logic [31:0] exp, input string req);
        logic [31:0] v;
        do_read(6'(4 + i), v);
        check(v == exp, req, v, exp);
    endtask

    task automatic expect_decode(input logic [31:0] a, input bit io, input bit hit, input logic [2:0] idx, input string req);
        @(negedge clk);
        dec_addr = a; dec_is_io = io;
        #1;
        check(dec_hit == hit, req, 32'(dec_hit), 32'(hit));
        check(dec_bar == idx, req, 32'(dec_bar), 32'(idx));
    endtask

    task automatic t_reset;
        check(win_en == '0, "R1 windows off", 32'(win_en), 32'h0);
        for (int i = 0; i < NB; i++) expect_bar(i, low_fixed(i), "R1 reset value");
    endtask

    task automatic t_probe;
        for (int i = 0; i < NB; i++) begin
            do_write(6'(4 + i), 4'hF, 32'hFFFF_FFFF);
            expect_bar(i, ~size_m1(i) | low_fixed(i), "R3 size readback");
        end
        check(win_en == '0, "R4 probe opens nothing", 32'(win_en), 32'h0);
    endtask

    task automatic t_program;
        do_write(6'd4, 4'hF, 32'h1234_5FFF);
        expect_bar(0, 32'h1234_5FF0, "R5 memory low bits");
        check(win_en[0] == 1'b1, "R7 window opened", 32'(win_en), 32'h1);
        check(win_base[31:0] == 32'h1234_5000, "R7 base", win_base[31:0], 32'h1234_5000);
        check(win_mask[31:0] == 32'h0000_0FFF, "R7 mask", win_mask[31:0], 32'h0000_0FFF);
        do_write(6'd5, 4'hF, 32'h0000_C0FF);
        expect_bar(1, 32'h0000_C0FD, "R5 io low bits");
        check(win_base[63:32] == 32'h0000_C000, "R7 io base", win_base[63:32], 32'h0000_C000);
        check(win_mask[63:32] == 32'h0000_00FF, "R7 io mask", win_mask[63:32], 32'h0000_00FF);
    endtask

    task automatic t_probe_after;
        do_write(6'd4, 4'hF, 32'hFFFF_FFFF);
        expect_bar(0, 32'hFFFF_F000, "R3 reprobe");
        check(win_en[0] && win_base[31:0] == 32'h1234_5000, "R4 window kept", win_base[31:0], 32'h1234_5000);
    endtask

    task automatic t_move;
        do_write(6'd4, 4'hF, 32'h2000_0000);
        check(win_base[31:0] == 32'h2000_0000, "R8 moved", win_base[31:0], 32'h2000_0000);
        do_write(6'd4, 4'hF, 32'h0);
        expect_bar(0, 32'h0, "R8 zero stored");
        check(win_en[0] && win_base[31:0] == 32'h2000_0000, "R8 zero keeps window", win_base[31:0], 32'h2000_0000);
    endtask

    task automatic t_partial;
        do_write(6'd6, 4'b1000, 32'hAB00_0000);
        expect_bar(2, 32'hABF0_0000, "R6 upper byte only");
        check(win_base[95:64] == 32'hABF0_0000, "R6 partial base", win_base[95:64], 32'hABF0_0000);
        do_write(6'd7, 4'b0001, 32'h0000_00AB);
        expect_bar(3, 32'hFFFF_FFA9, "R6 low byte fixed bits");
        check(win_base[127:96] == 32'hFFFF_FFA0, "R6 io partial base", win_base[127:96], 32'hFFFF_FFA0);
    endtask

    task automatic t_nonbar;
        logic [31:0] v;
        do_write(6'd3, 4'hF, 32'h5555_5555);
        do_read(6'd3, v);
        check(v == 32'h0, "R2 offset 3 reads zero", v, 32'h0);
        do_read(6'd10, v);
        check(v == 32'h0, "R2 offset 10 reads zero", v, 32'h0);
        expect_bar(0, 32'h0, "R2 bank untouched");
        check(win_en == 6'b001111, "R2 windows untouched", 32'(win_en), 32'h0F);
    endtask

    task automatic t_read_hold;
        logic [31:0] v;
        do_read(6'd5, v);
        check(v == 32'h0000_C0FD, "R11 read", v, 32'h0000_C0FD);
        do_write(6'd5, 4'hF, 32'h0000_D000);
        check(cfg_rdata == 32'h0000_C0FD, "R11 hold without read", cfg_rdata, 32'h0000_C0FD);
        expect_bar(1, 32'h0000_D001, "R11 fresh read");
    endtask

    task automatic t_decode;
        expect_decode(32'h2000_0ABC, 1'b0, 1'b1, 3'd0, "R9 memory hit");
        expect_decode(32'h2000_0ABC, 1'b1, 1'b0, 3'd0, "R9 type mismatch");
        expect_decode(32'h0000_D012, 1'b1, 1'b1, 3'd1, "R9 io hit");
        expect_decode(32'h0000_C012, 1'b1, 1'b0, 3'd0, "R9 old io base");
        expect_decode(32'h2000_1000, 1'b0, 1'b0, 3'd0, "R9 outside window");
        do_write(6'd8, 4'hF, 32'h2000_0000);
        expect_decode(32'h2000_0ABC, 1'b0, 1'b1, 3'd0, "R10 lowest wins");
        expect_decode(32'h2000_F000, 1'b0, 1'b1, 3'd4, "R10 only higher");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_probe();
        t_program();
        t_probe_after();
        t_move();
        t_partial();
        t_nonbar();
        t_read_hold();
        t_decode();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule